// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a 36-bit synchronous SRAM with a two-stage pipeline. Reads and writes may follow one another on every clock, in any order, and no idle cycle is needed between them. The bus is split into four byte lanes. Each lane has eight data bits and one parity bit, and each lane has its own active-low write select. Every synchronous input is sampled only on clock edges where the active-low clock enable is low. Raising the clock enable freezes the whole pipeline but does not deselect the device.

An access is started by a load cycle. A load carries an address, a write/read choice and a chip-select decision, which comes from three chip enables of mixed polarity. An advance cycle repeats the previous operation at the next address of a four-word burst. A small address generator produces that address sequence. The device returns read data one enabled edge after the address edge. It takes write data from the input port on the second enabled edge after the address edge, so read data and write data occupy the same bus slot. A read that lands directly behind a write to the same word returns the new bytes, merged lane by lane.

The bidirectional bus appears as three ports: data in, data out, and a drive enable. The asynchronous output enable gates the drive enable. The pipeline also holds the drive off during write data slots, during deselected slots and on the first slot after leaving deselect.

Top module: `nblSram`

## Requirements
- R1: On a rising edge with `cenN` high, nothing in the device changes: no memory write, no pipeline movement, no burst step. `dOut` and `dOe` keep their values.
- R2: A load (`advLd` low) selects the device only when `ce1N`=0, `ce2`=1 and `ce3N`=0. Any other combination starts no access, and the data slot that follows keeps `dOe` low.
- R3: A write sets lane i of the word only when `bwN[i]` is low. Lane i is data bits `[8i+7:8i]` plus parity bit `32+i`. Lanes whose select is high keep their old contents.
- R4: Parity bits 35:32 are stored and returned in the same way as data bits, under their own lane's select.
- R5: If a read address is captured on enabled edge k, the word is driven on `dOut`, with `dOe` high when `oeN` is low, from enabled edge k+1 until the next enabled edge.
- R6: If a write address is captured on enabled edge k, its data is taken from `dIn` on enabled edge k+2.
- R7: A read issued directly after a write to the same address returns the newly written lanes, with the other lanes taken from the old word.
- R8: `dOe` stays low during a write data slot, in the slot after a deselected cycle and while deselected, whatever `oeN` is.
- R9: `oeN` high forces `dOe` low at once, with no clock edge needed.
- R10: An advance cycle (`advLd` high) ignores the chip enables and `weN`. It repeats the previous command's selection and direction at the next burst address: upper address bits are kept, and the low two bits are the load address XOR the advance count (mod 4). It takes fresh byte selects. After a deselect, an advance stays deselected.
- R11: While `rstN` is low the pipeline is emptied, so `dOe` is low and `dOut` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low reset of pipeline state (memory is not cleared) |
| cenN | input | 1 | Active-low clock enable |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| advLd | input | 1 | 1 = advance burst, 0 = load new command |
| weN | input | 1 | Active-low write enable, sampled on loads |
| bwN | input | 4 | Active-low byte-lane write selects |
| addr | input | AW | Word address, sampled on loads |
| oeN | input | 1 | Asynchronous active-low output enable |
| dIn | input | 36 | Write data bus |
| dOut | output | 36 | Read data bus |
| dOe | output | 1 | Drive enable for the data bus |

## Verification
The hardest case to reach is the read-after-write merge when it coincides with stalls and bursts. Only a write immediately followed by a read of the same word, with no enabled edge between them, takes the bypass path, and a clock-enable stall between the two commands moves which `dIn` value counts. To reach this, the stimulus packs random traffic into eight addresses, mixes in stalls, burst advances and random byte masks, and changes `dIn` on every cycle. A behavioural model compares every slot against the device, applying each write before the read that follows it.

// File: rtl/nblSramPkg.sv
package nblSramPkg;
  localparam int LANES  = 4;
  localparam int LANE_D = 8;
  localparam int BUS_W  = LANES * (LANE_D + 1);

  typedef struct packed {
    logic             step;     // enabled edge
    logic             rdGo;     // read word at rdAddr on this edge
    logic             wrGo;     // write word at wrAddr on this edge
    logic             addrHit;  // rdAddr equals wrAddr
    logic [LANES-1:0] wrLanes;  // lanes written this edge
  } ctlStrobes_t;

  function automatic logic [BUS_W-1:0] laneMask(input logic [LANES-1:0] lanes);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) begin
      m[i*LANE_D +: LANE_D] = {LANE_D{lanes[i]}};
      m[LANES*LANE_D + i]   = lanes[i];
    end
    return m;
  endfunction
endpackage

// File: rtl/nblBurstAddr.sv
module nblBurstAddr #(
  parameter int AW = 6,
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          step,
  input  logic          advLd,
  input  logic [AW-1:0] addrIn,
  output logic [AW-1:0] addrNext
);
  logic [AW-1:0] base;
  logic [1:0]    cnt;
  logic [1:0]    cntNext;
  logic [1:0]    lowNext;

  assign cntNext = cnt + 2'd1;

  generate
    if (INTERLEAVE) begin : g_inter
      assign lowNext = base[1:0] ^ cntNext;
    end else begin : g_linear
      assign lowNext = base[1:0] + cntNext;
    end
  endgenerate

  assign addrNext = advLd ? {base[AW-1:2], lowNext} : addrIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      base <= '0;
      cnt  <= '0;
    end else if (step) begin
      if (advLd) begin
        cnt <= cntNext;
      end else begin
        base <= addrIn;
        cnt  <= '0;
      end
    end
  end

  // R10: every advance step moves the burst count by one
  assert_burst_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    (step && advLd) |=> (cnt == $past(cnt) + 2'd1));
endmodule

// File: rtl/nblCtl.sv
module nblCtl
  import nblSramPkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cenN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              advLd,
  input  logic              weN,
  input  logic [LANES-1:0]  bwN,
  input  logic [AW-1:0]     addrNext,
  output ctlStrobes_t       str,
  output logic [AW-1:0]     rdAddr,
  output logic [AW-1:0]     wrAddr,
  output logic              drive
);
  logic             step, selNow, newValid, newWrite;
  logic             s1Valid, s1Write, s2Valid, s2Write;
  logic [AW-1:0]    s1Addr, s2Addr;
  logic [LANES-1:0] s1Bw, s2Bw;

  assign step     = !cenN;
  assign selNow   = !ce1N && ce2 && !ce3N;
  assign newValid = advLd ? s1Valid : selNow;
  assign newWrite = advLd ? s1Write : !weN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Write <= 1'b0;
      s1Addr  <= '0;
      s1Bw    <= '0;
      s2Valid <= 1'b0;
      s2Write <= 1'b0;
      s2Addr  <= '0;
      s2Bw    <= '0;
      drive   <= 1'b0;
    end else if (step) begin
      s1Valid <= newValid;
      s1Write <= newWrite;
      s1Addr  <= addrNext;
      s1Bw    <= ~bwN;
      s2Valid <= s1Valid;
      s2Write <= s1Write;
      s2Addr  <= s1Addr;
      s2Bw    <= s1Bw;
      drive   <= s1Valid && !s1Write;
    end
  end

  always_comb begin
    str.step    = step;
    str.rdGo    = step && s1Valid && !s1Write;
    str.wrGo    = step && s2Valid && s2Write;
    str.addrHit = (s1Addr == s2Addr);
    str.wrLanes = (step && s2Valid && s2Write) ? s2Bw : '0;
  end

  assign rdAddr = s1Addr;
  assign wrAddr = s2Addr;

  // R1: a masked edge freezes the pipeline
  assert_stall_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    cenN |=> ($stable(s1Valid) && $stable(s2Valid) && $stable(drive) && $stable(s1Addr)));
  // R2: a load with chip enables not all active starts nothing
  assert_deselect_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!cenN && !advLd && !(!ce1N && ce2 && !ce3N)) |=> !s1Valid);
  // R5: drive follows a selected read one enabled edge later
  assert_read_slot_R5: assert property (@(posedge clk) disable iff (!rstN)
    !cenN |=> (drive == $past(s1Valid && !s1Write)));
  // R8: no drive in a write data slot
  assert_no_drive_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!cenN && s1Valid && s1Write) |=> !drive);
endmodule

// File: rtl/nblData.sv
module nblData
  import nblSramPkg::*;
#(
  parameter int AW    = 6,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      str,
  input  logic [AW-1:0]    rdAddr,
  input  logic [AW-1:0]    wrAddr,
  input  logic [BUS_W-1:0] dIn,
  output logic [BUS_W-1:0] dOut
);
  logic [BUS_W-1:0] mem [DEPTH];
  logic [BUS_W-1:0] wrMask, rdRaw, merged;

  assign wrMask = laneMask(str.wrLanes);
  assign rdRaw  = mem[rdAddr];
  assign merged = str.addrHit ? ((rdRaw & ~wrMask) | (dIn & wrMask)) : rdRaw;

  always_ff @(posedge clk) begin
    if (str.wrGo) begin
      mem[wrAddr] <= (mem[wrAddr] & ~wrMask) | (dIn & wrMask);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dOut <= '0;
    end else if (str.rdGo) begin
      dOut <= merged;
    end
  end

  // R7: a read colliding with the write on the same edge sees the new lanes
  assert_bypass_merge_R7: assert property (@(posedge clk) disable iff (!rstN)
    (str.rdGo && str.wrGo && str.addrHit) |=>
      ((dOut & $past(wrMask)) == ($past(dIn) & $past(wrMask))));
endmodule

// File: rtl/nblSram.sv
module nblSram
  import nblSramPkg::*;
#(
  parameter int DEPTH = 64,
  parameter bit INTERLEAVE = 1'b1,
  localparam int AW = (DEPTH < 8) ? 3 : $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cenN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             advLd,
  input  logic             weN,
  input  logic [LANES-1:0] bwN,
  input  logic [AW-1:0]    addr,
  input  logic             oeN,
  input  logic [BUS_W-1:0] dIn,
  output logic [BUS_W-1:0] dOut,
  output logic             dOe
);
  ctlStrobes_t   str;
  logic [AW-1:0] addrNext, rdAddr, wrAddr;
  logic          drive;

  nblBurstAddr #(.AW(AW), .INTERLEAVE(INTERLEAVE)) uAgen (
    .clk(clk), .rstN(rstN), .step(!cenN), .advLd(advLd),
    .addrIn(addr), .addrNext(addrNext)
  );

  nblCtl #(.AW(AW)) uCtl (
    .clk(clk), .rstN(rstN), .cenN(cenN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .advLd(advLd), .weN(weN), .bwN(bwN), .addrNext(addrNext),
    .str(str), .rdAddr(rdAddr), .wrAddr(wrAddr), .drive(drive)
  );

  nblData #(.AW(AW), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .str(str), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .dIn(dIn), .dOut(dOut)
  );

  assign dOe = drive && !oeN;
endmodule

// File: tb/tb_nblSram.sv
`timescale 1ns/100ps
module tb_nblSram;
  logic        clk = 1'b0;
  logic        rstN, cenN, ce1N, ce2, ce3N, advLd, weN, oeN;
  logic [3:0]  bwN;
  logic [5:0]  addr;
  logic [35:0] dIn;
  logic [35:0] dOut;
  logic        dOe;

  int total = 0;
  int bad = 0;
  string curTag = "R5";

  nblSram dut (.clk(clk), .rstN(rstN), .cenN(cenN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
               .advLd(advLd), .weN(weN), .bwN(bwN), .addr(addr), .oeN(oeN),
               .dIn(dIn), .dOut(dOut), .dOe(dOe));

  always #2 clk = ~clk;

  // behavioural reference
  logic [35:0] mdl [64];
  logic        aSel = 0, aWr = 0, bSel = 0, bWr = 0;
  logic [5:0]  aAddr = 0, bAddr = 0, baseM = 0;
  logic [3:0]  aBw = 0, bBw = 0;
  logic [1:0]  cntM = 0;
  logic        drvM = 0;
  logic [35:0] expD = 0;

  function automatic logic [35:0] mk(input logic [3:0] lanes);
    logic [35:0] m = '0;
    for (int i = 0; i < 4; i++) begin
      if (lanes[i]) begin
        m[i*8 +: 8] = 8'hFF;
        m[32+i] = 1'b1;
      end
    end
    return m;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic c, input logic [2:0] ces, input logic adv, input logic we,
                     input logic [3:0] bw, input logic [5:0] a, input logic oe);
    logic nSel, nWr;
    logic [5:0] nAddr;
    @(negedge clk);
    cenN = c; {ce1N, ce2, ce3N} = ces; advLd = adv; weN = we; bwN = bw; addr = a; oeN = oe;
    dIn = {$urandom(), $urandom()} & 36'hF_FFFF_FFFF;
    @(posedge clk);
    #1;
    if (!c) begin
      if (bSel && bWr) mdl[bAddr] = (mdl[bAddr] & ~mk(bBw)) | (dIn & mk(bBw));
      drvM = aSel && !aWr;
      if (drvM) expD = mdl[aAddr];
      if (adv) begin
        cntM = cntM + 2'd1;
        nSel = aSel; nWr = aWr;
        nAddr = {baseM[5:2], baseM[1:0] ^ cntM};
      end else begin
        baseM = a; cntM = 0;
        nSel = (ces == 3'b010); nWr = !we; nAddr = a;
      end
      bSel = aSel; bWr = aWr; bAddr = aAddr; bBw = aBw;
      aSel = nSel; aWr = nWr; aAddr = nAddr; aBw = ~bw;
    end
    chk(dOe == (drvM && !oe), {curTag, " R8 drive"}, {35'd0, dOe}, {35'd0, drvM && !oe});
    if (drvM && !oe) chk(dOut == expD, {curTag, " data"}, dOut, expD);
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] bw);
    cyc(0, 3'b010, 0, 0, bw, a, 0);
  endtask
  task automatic rd(input logic [5:0] a);
    cyc(0, 3'b010, 0, 1, 4'hF, a, 0);
  endtask
  task automatic desel();
    cyc(0, 3'b110, 0, 1, 4'hF, 6'd0, 0);
  endtask

  initial begin
    #(4 * 190000);
    chk(1'b0, "watchdog", 36'd0, 36'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 0; cenN = 1; ce1N = 1; ce2 = 0; ce3N = 1; advLd = 0; weN = 1; bwN = 4'hF;
    addr = 0; oeN = 0; dIn = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(dOe == 0 && dOut == 0, "R11 reset", dOut, 36'd0);
    @(negedge clk); rstN = 1;

    curTag = "R6";
    for (int i = 0; i < 64; i++) wr(i[5:0], 4'h0);
    desel(); desel();
    curTag = "R5";
    for (int i = 0; i < 64; i++) rd(i[5:0]);
    desel(); desel();

    curTag = "R3";
    wr(6'd5, 4'b1010); desel(); desel(); rd(6'd5); desel();
    curTag = "R4";
    wr(6'd6, 4'b0111); desel(); desel(); rd(6'd6); desel();

    curTag = "R7";
    wr(6'd9, 4'b0101); rd(6'd9); rd(6'd9); desel();
    wr(6'd10, 4'h0); rd(6'd10); wr(6'd10, 4'b1100); rd(6'd10); desel(); desel();

    curTag = "R2";
    cyc(0, 3'b000, 0, 1, 4'hF, 6'd1, 0); cyc(0, 3'b011, 0, 1, 4'hF, 6'd1, 0);
    cyc(0, 3'b110, 0, 0, 4'h0, 6'd1, 0); desel();
    curTag = "R8";
    rd(6'd2); rd(6'd3); wr(6'd4, 4'h0); rd(6'd4); desel(); desel();

    curTag = "R10";
    rd(6'd22); cyc(0, 3'b110, 1, 0, 4'hF, 6'd0, 0);
    cyc(0, 3'b000, 1, 0, 4'h0, 6'd0, 0); cyc(0, 3'b010, 1, 1, 4'hF, 6'd0, 0);
    wr(6'd13, 4'h0); cyc(0, 3'b110, 1, 1, 4'b0011, 6'd0, 0); cyc(0, 3'b010, 1, 1, 4'h0, 6'd0, 0);
    desel(); cyc(0, 3'b010, 1, 0, 4'h0, 6'd0, 0); desel();
    rd(6'd12); rd(6'd13); rd(6'd14); rd(6'd15); desel();

    curTag = "R1";
    rd(6'd7); cyc(1, 3'b010, 0, 0, 4'h0, 6'd8, 0); cyc(1, 3'b110, 0, 1, 4'hF, 6'd9, 0);
    rd(6'd8); wr(6'd8, 4'h0); cyc(1, 3'b010, 0, 1, 4'hF, 6'd8, 0); rd(6'd8);
    desel(); desel();

    curTag = "R9";
    rd(6'd11); rd(6'd11);
    #0.5 oeN = 1; #0.2;
    chk(dOe == 0, "R9 async off", {35'd0, dOe}, 36'd0);
    oeN = 0; #0.2;
    chk(dOe == 1, "R9 async on", {35'd0, dOe}, 36'd1);
    desel(); desel();

    curTag = "R7 mix";
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] ces;
      ces = ($urandom % 8 == 0) ? 3'($urandom) : 3'b010;
      cyc(($urandom % 5) == 0, ces, ($urandom % 4) == 0, $urandom % 2 == 0,
          4'($urandom), 6'($urandom % 8), ($urandom % 10) == 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule